// File: doc/BRIEF.md
# CAN Operating Mode Controller

This block decides which operating mode a CAN controller is in: sleep, initialization, resynchronization, normal operation or bus-off. Software control bits arrive as plain level inputs: an initialization request, a sleep request, an automatic wake-up enable and an automatic bus-off recovery enable. The protocol engine supplies a received bit value with a one-cycle bit-time strobe, a frame-busy level, a start-of-frame pulse and a bus-off entry pulse. The block returns acknowledge flags for initialization and sleep, a ready indication for normal operation, and a one-cycle pulse that tells the register file to clear the software sleep request.

Requests to change mode wait until the frame in progress has finished. Getting back onto the bus requires a run of recessive bits. After initialization or sleep, one run of 11 consecutive recessive bits is enough. After bus-off, 128 such runs are needed, and recovery can either happen automatically or wait for a set-then-clear handshake on the initialization request. There is no data stream at this block's edge, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, sleep_ack_o=1, init_ack_o=0, sync_ready_o=0 and sleep_req_clr_o=0. The block starts asleep.
- R2: While ready, setting init_req_i with frame_busy_i=1 keeps the mode unchanged. Once frame_busy_i falls, init_ack_o=1 and sync_ready_o=0 on the following cycle.
- R3: After init_req_i is cleared, init_ack_o stays 1 until 11 consecutive strobed bits with rx_bit_i=1 (1 = recessive) have been seen. On the 11th, init_ack_o falls and sync_ready_o rises. Ten bits are not enough.
- R4: A strobed bit with rx_bit_i=0 (dominant) during resynchronization restarts the count of consecutive recessive bits from zero.
- R5: A sleep request from normal mode waits while frame_busy_i=1. After that, sleep_ack_o=1. Clearing sleep_req_i leaves sleep, and 11 recessive bits then restore sync_ready_o.
- R6: While asleep with auto_wake_i=1, a sof_det_i pulse clears sleep_ack_o and pulses sleep_req_clr_o for exactly one cycle. With auto_wake_i=0, sof_det_i has no effect.
- R7: When init_req_i and sleep_req_i are both asserted, initialization wins: init_ack_o=1 and sleep_ack_o=0.
- R8: A busoff_enter_i pulse in normal mode clears sync_ready_o on the next cycle, even if a frame is busy.
- R9: With auto_busoff_i=1, bus-off is left for normal mode on the strobe that completes the 128th run of 11 recessive bits. After 127 runs plus 10 bits, the block is still in bus-off.
- R10: During bus-off, a dominant bit discards only the partial run in progress. Runs already completed still count.
- R11: With auto_busoff_i=0, completing 128 runs alone does not leave bus-off. Exit happens once software has also set and then cleared init_req_i while in bus-off.
- R12: At most one of init_ack_o, sleep_ack_o and sync_ready_o is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| init_req_i | input | 1 | Software initialization request |
| sleep_req_i | input | 1 | Software sleep request |
| auto_wake_i | input | 1 | Wake automatically on start of frame |
| auto_busoff_i | input | 1 | Recover from bus-off without software |
| rx_bit_i | input | 1 | Sampled bus bit, 1 = recessive |
| bit_strobe_i | input | 1 | One-cycle pulse marking rx_bit_i valid |
| frame_busy_i | input | 1 | A frame is being sent or received |
| sof_det_i | input | 1 | Start-of-frame detected pulse |
| busoff_enter_i | input | 1 | Error logic entered bus-off pulse |
| init_ack_o | output | 1 | Initialization mode acknowledged |
| sleep_ack_o | output | 1 | Sleep mode acknowledged |
| sync_ready_o | output | 1 | Synchronized, normal operation |
| sleep_req_clr_o | output | 1 | One-cycle request to clear the sleep bit |

## Verification
The bench targets several off-by-one boundaries:
- Exactly ten versus eleven recessive bits. A counter off by one would report ready too early or too late.
- 127 runs plus ten bits versus the full 128th run. An off-by-one here would make bus-off recovery end early or late.

Dominant bits are placed inside runs, both during resynchronization and during bus-off. A design that forgot to restart the run would synchronize too soon. A design that also wiped completed bus-off runs would never recover.

Deferral under a busy frame, init winning over sleep, a start of frame with wake-up disabled, and software-gated recovery without the handshake are each driven directly. Random recessive/dominant streams are checked against a bench model of the consecutive count.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  typedef enum logic [2:0] {
    MODE_SLEEP  = 3'd0,
    MODE_INIT   = 3'd1,
    MODE_SYNC   = 3'd2,
    MODE_NORMAL = 3'd3,
    MODE_BUSOFF = 3'd4
  } mode_e;
endpackage

// File: rtl/recessive_run_cnt.sv
// Counts consecutive recessive bits; pulses when a full run completes.
module recessive_run_cnt #(
  parameter int RUN_BITS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic strobe_i,
  input  logic rx_i,
  output logic run_done_o
);
  localparam int CW = $clog2(RUN_BITS);

  logic [CW-1:0] cnt_q;

  assign run_done_o = strobe_i && rx_i && !clr_i && (cnt_q == CW'(RUN_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (strobe_i) begin
      if (!rx_i || run_done_o) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/busoff_recovery.sv
// Tallies completed recessive runs during bus-off and gates the exit.
module busoff_recovery #(
  parameter int RECOV_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic run_done_i,
  input  logic init_req_i,
  input  logic auto_i,
  output logic release_o
);
  localparam int RW = $clog2(RECOV_RUNS + 1);

  logic [RW-1:0] runs_q;
  logic          seen_set_q;
  logic          sw_ok_q;
  logic          runs_met;

  assign runs_met  = (runs_q == RW'(RECOV_RUNS)) ||
                     (run_done_i && runs_q == RW'(RECOV_RUNS - 1));
  assign release_o = active_i && runs_met && (auto_i || sw_ok_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      runs_q     <= '0;
      seen_set_q <= 1'b0;
      sw_ok_q    <= 1'b0;
    end else if (!active_i) begin
      runs_q     <= '0;
      seen_set_q <= 1'b0;
      sw_ok_q    <= 1'b0;
    end else begin
      if (run_done_i && runs_q != RW'(RECOV_RUNS)) runs_q <= runs_q + 1'b1;
      if (init_req_i)                seen_set_q <= 1'b1;
      if (seen_set_q && !init_req_i) sw_ok_q    <= 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
  parameter int RUN_BITS   = 11,
  parameter int RECOV_RUNS = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init_req_i,
  input  logic sleep_req_i,
  input  logic auto_wake_i,
  input  logic auto_busoff_i,
  input  logic rx_bit_i,
  input  logic bit_strobe_i,
  input  logic frame_busy_i,
  input  logic sof_det_i,
  input  logic busoff_enter_i,
  output logic init_ack_o,
  output logic sleep_ack_o,
  output logic sync_ready_o,
  output logic sleep_req_clr_o
);
  import can_mode_pkg::*;

  mode_e mode_q, mode_d;
  logic  init_ack_q, init_ack_d;
  logic  clr_q, clr_d;
  logic  run_done;
  logic  recov_release;
  logic  sleep_go;

  recessive_run_cnt #(.RUN_BITS(RUN_BITS)) u_run (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (!(mode_q == MODE_SYNC || mode_q == MODE_BUSOFF)),
    .strobe_i   (bit_strobe_i),
    .rx_i       (rx_bit_i),
    .run_done_o (run_done)
  );

  busoff_recovery #(.RECOV_RUNS(RECOV_RUNS)) u_recov (
    .clk        (clk),
    .rst_n      (rst_n),
    .active_i   (mode_q == MODE_BUSOFF),
    .run_done_i (run_done),
    .init_req_i (init_req_i),
    .auto_i     (auto_busoff_i),
    .release_o  (recov_release)
  );

  // The sleep request is masked for the cycle in which its clear is pending.
  assign sleep_go = sleep_req_i && !clr_q;

  always_comb begin
    mode_d     = mode_q;
    init_ack_d = init_ack_q;
    clr_d      = 1'b0;
    unique case (mode_q)
      MODE_SLEEP: begin
        if (init_req_i) begin
          mode_d     = MODE_INIT;
          init_ack_d = 1'b1;
        end else if (auto_wake_i && sof_det_i) begin
          mode_d = MODE_SYNC;
          clr_d  = 1'b1;
        end else if (!sleep_req_i) begin
          mode_d = MODE_SYNC;
        end
      end
      MODE_INIT: begin
        if (!init_req_i) begin
          if (sleep_go) begin
            mode_d     = MODE_SLEEP;
            init_ack_d = 1'b0;
          end else begin
            mode_d = MODE_SYNC;
          end
        end
      end
      MODE_SYNC: begin
        if (init_req_i && !frame_busy_i) begin
          mode_d     = MODE_INIT;
          init_ack_d = 1'b1;
        end else if (sleep_go && !frame_busy_i) begin
          mode_d     = MODE_SLEEP;
          init_ack_d = 1'b0;
        end else if (run_done) begin
          mode_d     = MODE_NORMAL;
          init_ack_d = 1'b0;
        end
      end
      MODE_NORMAL: begin
        if (busoff_enter_i) begin
          mode_d = MODE_BUSOFF;
        end else if (init_req_i && !frame_busy_i) begin
          mode_d     = MODE_INIT;
          init_ack_d = 1'b1;
        end else if (sleep_go && !frame_busy_i) begin
          mode_d = MODE_SLEEP;
        end
      end
      MODE_BUSOFF: begin
        if (recov_release) mode_d = MODE_NORMAL;
      end
      default: mode_d = MODE_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_SLEEP;
      init_ack_q <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      init_ack_q <= init_ack_d;
      clr_q      <= clr_d;
    end
  end

  assign init_ack_o      = init_ack_q;
  assign sleep_ack_o     = (mode_q == MODE_SLEEP);
  assign sync_ready_o    = (mode_q == MODE_NORMAL);
  assign sleep_req_clr_o = clr_q;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic init_req_i,
  input logic auto_wake_i,
  input logic frame_busy_i,
  input logic sof_det_i,
  input logic busoff_enter_i,
  input logic init_ack_o,
  input logic sleep_ack_o,
  input logic sync_ready_o,
  input logic sleep_req_clr_o
);
  // R12
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({init_ack_o, sleep_ack_o, sync_ready_o}) <= 1);

  // R8
  busoff_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ready_o && busoff_enter_i |=> !sync_ready_o);

  // R2
  init_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ready_o && frame_busy_i && init_req_i && !busoff_enter_i |=> sync_ready_o && !init_ack_o);

  // R5
  sleep_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ready_o && frame_busy_i && !busoff_enter_i |=> !sleep_ack_o);

  // R6
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack_o && auto_wake_i && sof_det_i && !init_req_i |=> sleep_req_clr_o && !sleep_ack_o);

  // R6
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_req_clr_o |=> !sleep_req_clr_o);

  // R7
  init_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_ack_o && init_req_i |=> init_ack_o && !sleep_ack_o);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (.*);

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_req_i = 1'b0, sleep_req_i = 1'b1, auto_wake_i = 1'b0, auto_busoff_i = 1'b1;
  logic rx_bit_i = 1'b1, bit_strobe_i = 1'b0, frame_busy_i = 1'b0;
  logic sof_det_i = 1'b0, busoff_enter_i = 1'b0;
  logic init_ack_o, sleep_ack_o, sync_ready_o, sleep_req_clr_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  can_mode_ctrl u_dut (.*);

  // Expected {init_ack, sleep_ack, ready} encodings
  function automatic logic [2:0] exp_mode(input bit ia, input bit sa, input bit rd);
    return {ia, sa, rd};
  endfunction

  function automatic logic [2:0] exp_sync(input int run);
    return (run >= 11) ? exp_mode(0, 0, 1) : exp_mode(1, 0, 0);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_mode(input string req, input logic [2:0] exp);
    chk(req, {29'd0, init_ack_o, sleep_ack_o, sync_ready_o}, {29'd0, exp});
    // R12: never two mode flags together
    chk("R12", $countones({init_ack_o, sleep_ack_o, sync_ready_o}) <= 1, 1);
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bits(input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      rx_bit_i = v;
      bit_strobe_i = 1'b1;
      @(negedge clk);
      bit_strobe_i = 1'b0;
      rx_bit_i = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic busoff_pulse();
    busoff_enter_i = 1'b1;
    @(negedge clk);
    busoff_enter_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
    // R1: reset state
    chk_mode("R1", exp_mode(0, 1, 0));
    chk("R1 clr", sleep_req_clr_o, 0);

    // R7: init and sleep both requested
    init_req_i = 1'b1;
    cyc(2);
    chk_mode("R7", exp_mode(1, 0, 0));

    // R3: ten recessive bits then the eleventh
    init_req_i = 1'b0;
    sleep_req_i = 1'b0;
    cyc(2);
    bits(10, 1'b1);
    chk_mode("R3 ten bits", exp_mode(1, 0, 0));
    bits(1, 1'b1);
    chk_mode("R3 eleven bits", exp_mode(0, 0, 1));

    // R4: dominant restarts the run
    init_req_i = 1'b1;
    cyc(2);
    init_req_i = 1'b0;
    cyc(2);
    bits(6, 1'b1);
    bits(1, 1'b0);
    bits(10, 1'b1);
    chk_mode("R4 after restart", exp_mode(1, 0, 0));
    bits(1, 1'b1);
    chk_mode("R4 run done", exp_mode(0, 0, 1));

    // R2: init deferred while frame busy
    frame_busy_i = 1'b1;
    init_req_i = 1'b1;
    cyc(3);
    chk_mode("R2 deferred", exp_mode(0, 0, 1));
    frame_busy_i = 1'b0;
    cyc(1);
    chk_mode("R2 entered", exp_mode(1, 0, 0));
    init_req_i = 1'b0;
    cyc(1);
    bits(11, 1'b1);
    chk_mode("R3 resync", exp_mode(0, 0, 1));

    // R5: sleep deferred, then exit by software
    frame_busy_i = 1'b1;
    sleep_req_i = 1'b1;
    cyc(3);
    chk_mode("R5 deferred", exp_mode(0, 0, 1));
    frame_busy_i = 1'b0;
    cyc(1);
    chk_mode("R5 asleep", exp_mode(0, 1, 0));
    sleep_req_i = 1'b0;
    cyc(2);
    chk_mode("R5 left sleep", exp_mode(0, 0, 0));
    bits(11, 1'b1);
    chk_mode("R5 ready", exp_mode(0, 0, 1));

    // R6: start of frame ignored without auto wake, honoured with it
    sleep_req_i = 1'b1;
    cyc(2);
    chk_mode("R6 asleep", exp_mode(0, 1, 0));
    sof_det_i = 1'b1;
    cyc(1);
    sof_det_i = 1'b0;
    cyc(1);
    chk_mode("R6 no wake", exp_mode(0, 1, 0));
    chk("R6 no clr", sleep_req_clr_o, 0);
    auto_wake_i = 1'b1;
    sof_det_i = 1'b1;
    cyc(1);
    sof_det_i = 1'b0;
    chk("R6 clr pulse", sleep_req_clr_o, 1);
    chk_mode("R6 woke", exp_mode(0, 0, 0));
    sleep_req_i = 1'b0;
    cyc(1);
    chk("R6 clr single", sleep_req_clr_o, 0);
    bits(11, 1'b1);
    chk_mode("R6 ready", exp_mode(0, 0, 1));
    auto_wake_i = 1'b0;

    // R8, R9, R10: automatic bus-off recovery
    auto_busoff_i = 1'b1;
    frame_busy_i = 1'b1;
    busoff_pulse();
    frame_busy_i = 1'b0;
    chk_mode("R8 ready dropped", exp_mode(0, 0, 0));
    bits(5 * 11, 1'b1);
    bits(4, 1'b1);
    bits(1, 1'b0);
    bits(122 * 11, 1'b1);
    bits(10, 1'b1);
    chk_mode("R9 not yet", exp_mode(0, 0, 0));
    bits(1, 1'b1);
    chk_mode("R10 R9 recovered", exp_mode(0, 0, 1));

    // R11: software-gated recovery
    auto_busoff_i = 1'b0;
    busoff_pulse();
    bits(128 * 11, 1'b1);
    cyc(2);
    chk_mode("R11 held", exp_mode(0, 0, 0));
    init_req_i = 1'b1;
    cyc(2);
    chk_mode("R11 set only", exp_mode(0, 0, 0));
    init_req_i = 1'b0;
    cyc(3);
    chk_mode("R11 recovered", exp_mode(0, 0, 1));
    auto_busoff_i = 1'b1;

    // R3, R4: random recessive/dominant streams against a run model
    for (int round = 0; round < 4; round++) begin
      int run = 0;
      init_req_i = 1'b1;
      cyc(2);
      init_req_i = 1'b0;
      cyc(1);
      for (int k = 0; k < 400 && run < 11; k++) begin
        logic v;
        v = ($urandom % 100) < 82;
        bits(1, v);
        run = v ? run + 1 : 0;
        chk_mode(v ? "R3 random" : "R4 random", exp_sync(run));
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule